// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, every clock cycle, which hardware thread of a fine-grain multithreaded scalar core may issue next. Each thread reports whether it has an instruction ready and whether it is speculating that an outstanding load will hit. The block also keeps two stall flags per thread, one for a cache miss and one for a long-latency operation. A start pulse sets the flag and a done pulse clears it.

Selection uses two tiers. Eligible threads that are not speculating form the upper tier, and eligible speculating threads form the lower tier. The lower tier is considered only when the upper tier is empty. Within the tier in use, a rotating pointer picks the first requesting thread at or after the pointer, wrapping around. After a grant, the pointer moves to the thread after the winner. Grant outputs are combinational from the current inputs and the registered state, so they apply in the same cycle.

Top module: `thread_selector`

## Requirements
- R1: A thread is eligible only when its ready bit is 1, its miss flag is clear and its long-op flag is clear. An ineligible thread is never granted.
- R2: A miss start pulse on a thread masks that thread in the same cycle and in every later cycle up to and including the cycle of its miss done pulse. The thread can be granted from the cycle after the done pulse.
- R3: A long-op start pulse and a long-op done pulse affect the long-op flag with the same timing as R2.
- R4: When at least one eligible thread has its speculation bit at 0, the grant goes to such a thread.
- R5: A thread whose speculation bit is 1 is granted only when no eligible thread has its speculation bit at 0.
- R6: Within the chosen tier, the winner is the first requesting thread found by scanning from the pointer in ascending index order, wrapping from the last thread to thread 0.
- R7: After a cycle with a grant to thread k, the pointer becomes (k+1) mod NTHR.
- R8: When no thread is eligible, gnt_valid is 0, gnt_vec is all zero, gnt_id is 0, and the pointer keeps its value.
- R9: gnt_vec has at most one bit set. That bit is set exactly when gnt_valid is 1, and gnt_id equals its index (bit i of gnt_vec means thread i).
- R10: A synchronous active-high reset clears every miss flag and long-op flag and sets the pointer to thread 0.
- R11: If a start pulse and a done pulse reach the same flag in the same cycle, the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_ready | input | NTHR | Per-thread ready bit |
| thr_spec | input | NTHR | Per-thread load-hit speculation bit |
| miss_start | input | NTHR | Pulse: a cache miss begins |
| miss_done | input | NTHR | Pulse: a cache miss resolves |
| lop_start | input | NTHR | Pulse: a long-latency operation begins |
| lop_done | input | NTHR | Pulse: a long-latency operation completes |
| gnt_valid | output | 1 | A thread is granted this cycle |
| gnt_vec | output | NTHR | One-hot grant |
| gnt_id | output | ID_W | Index of the granted thread |

## Verification
Grant outputs are combinational, so a thread's ready and speculation bits, and a start pulse, affect the grant in the same cycle. Done pulses and pointer movement appear in the first cycle after the clock edge. The bench changes inputs just after the falling edge and compares all three outputs with a behavioural model shortly before the next rising edge. The model state is then advanced with the same inputs, so a one-cycle delay is checked as exactly one cycle. The directed sequences probe a thread in the cycle of its done pulse and in the cycle after it. A long random run then covers the rotation and tier corner cases.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;

  // index of the thread that follows idx, wrapping at n
  function automatic int wrap_next(input int idx, input int n);
    return (idx >= n - 1) ? 0 : idx + 1;
  endfunction

  // scan position k places after base, modulo n
  function automatic int scan_pos(input int base, input int k, input int n);
    return (base + k) % n;
  endfunction

endpackage

// File: rtl/stall_flag.sv
module stall_flag (
  input  logic clk,
  input  logic rst,
  input  logic ev_start,
  input  logic ev_done,
  output logic flag_q,
  output logic blocked
);

  // start overrides done when both arrive together
  logic flag_d;
  assign flag_d  = ev_start | (flag_q & ~ev_done);
  assign blocked = flag_q | ev_start;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (ev_done && !ev_start) |=> !flag_q); // R2
  AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> flag_q); // R11

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          hit,
  output logic [PW-1:0] idx,
  output logic [N-1:0]  onehot
);
  import thr_sel_pkg::*;

  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = scan_pos(int'(ptr), k, N);
      if (!hit && req[j]) begin
        hit       = 1'b1;
        idx       = PW'(j);
        onehot[j] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/thread_selector.sv
module thread_selector #(
  parameter int NTHR = 4,
  localparam int ID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTHR-1:0] thr_ready,
  input  logic [NTHR-1:0] thr_spec,
  input  logic [NTHR-1:0] miss_start,
  input  logic [NTHR-1:0] miss_done,
  input  logic [NTHR-1:0] lop_start,
  input  logic [NTHR-1:0] lop_done,
  output logic            gnt_valid,
  output logic [NTHR-1:0] gnt_vec,
  output logic [ID_W-1:0] gnt_id
);
  import thr_sel_pkg::*;

  logic [NTHR-1:0] miss_q, miss_blk, lop_q, lop_blk;
  logic [NTHR-1:0] elig, hi_req, lo_req;
  logic [ID_W-1:0] ptr_q;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    stall_flag u_miss (
      .clk(clk), .rst(rst), .ev_start(miss_start[t]), .ev_done(miss_done[t]),
      .flag_q(miss_q[t]), .blocked(miss_blk[t])
    );
    stall_flag u_lop (
      .clk(clk), .rst(rst), .ev_start(lop_start[t]), .ev_done(lop_done[t]),
      .flag_q(lop_q[t]), .blocked(lop_blk[t])
    );
  end

  assign elig   = thr_ready & ~miss_blk & ~lop_blk;
  assign hi_req = elig & ~thr_spec;
  assign lo_req = elig & thr_spec;

  logic            hi_hit, lo_hit;
  logic [ID_W-1:0] hi_idx, lo_idx;
  logic [NTHR-1:0] hi_oh, lo_oh;

  rr_pick #(.N(NTHR), .PW(ID_W)) u_hi (
    .req(hi_req), .ptr(ptr_q), .hit(hi_hit), .idx(hi_idx), .onehot(hi_oh)
  );
  rr_pick #(.N(NTHR), .PW(ID_W)) u_lo (
    .req(lo_req), .ptr(ptr_q), .hit(lo_hit), .idx(lo_idx), .onehot(lo_oh)
  );

  always_comb begin
    if (hi_hit) begin
      gnt_valid = 1'b1; gnt_vec = hi_oh; gnt_id = hi_idx;
    end else if (lo_hit) begin
      gnt_valid = 1'b1; gnt_vec = lo_oh; gnt_id = lo_idx;
    end else begin
      gnt_valid = 1'b0; gnt_vec = '0; gnt_id = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ptr_q <= '0;
    else if (gnt_valid) ptr_q <= ID_W'(wrap_next(int'(gnt_id), NTHR));
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_vec) && (gnt_valid == (|gnt_vec))); // R9
  AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    (gnt_vec & ~elig) == '0); // R1
  AST_STALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (gnt_vec & (miss_q | lop_q)) == '0); // R2
  AST_UPPER_FIRST: assert property (@(posedge clk) disable iff (rst)
    (|hi_req) |-> (gnt_valid && ((gnt_vec & thr_spec) == '0))); // R4
  AST_LOWER_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && (|(gnt_vec & thr_spec))) |-> (hi_req == '0)); // R5
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |=> (int'(ptr_q) == wrap_next(int'($past(gnt_id)), NTHR))); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !gnt_valid |=> $stable(ptr_q)); // R8

endmodule

// File: tb/sim_thread_selector.sv
`timescale 1ns/1ps
module sim_thread_selector;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] rdy = '0, spc = '0, ms = '0, md = '0, ls = '0, ld = '0;
  logic gv;
  logic [N-1:0] gvec;
  logic [1:0] gid;

  always #4 clk = ~clk;

  thread_selector #(.NTHR(N)) u0 (
    .clk(clk), .rst(rst), .thr_ready(rdy), .thr_spec(spc),
    .miss_start(ms), .miss_done(md), .lop_start(ls), .lop_done(ld),
    .gnt_valid(gv), .gnt_vec(gvec), .gnt_id(gid)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_ptr = 0;
  bit m_miss[N];
  bit m_lop[N];

  task automatic model_reset();
    m_ptr = 0;
    for (int i = 0; i < N; i++) begin m_miss[i] = 0; m_lop[i] = 0; end
  endtask

  task automatic check(input string tag, input logic [N-1:0] r, s, a, b, c, d);
    int win;
    logic [N-1:0] exp_vec;
    bit elg[N];
    rdy = r; spc = s; ms = a; md = b; ls = c; ld = d;
    #2;
    for (int i = 0; i < N; i++)
      elg[i] = r[i] && !(m_miss[i] || a[i]) && !(m_lop[i] || c[i]);
    win = -1;
    for (int k = 0; k < N && win < 0; k++)
      if (elg[(m_ptr + k) % N] && !s[(m_ptr + k) % N]) win = (m_ptr + k) % N;
    for (int k = 0; k < N && win < 0; k++)
      if (elg[(m_ptr + k) % N] && s[(m_ptr + k) % N]) win = (m_ptr + k) % N;
    exp_vec = (win < 0) ? '0 : (N'(1) << win);
    n_chk++;
    if (gv !== (win >= 0) || gvec !== exp_vec) begin
      n_bad++;
      $display("FAIL %s: valid=%0b vec=%b expected valid=%0b vec=%b",
               tag, gv, gvec, (win >= 0), exp_vec);
    end
    n_chk++;
    if (gid !== ((win < 0) ? 2'd0 : 2'(win))) begin
      n_bad++;
      $display("FAIL R9: id=%0d expected %0d", gid, (win < 0) ? 0 : win);
    end
    for (int i = 0; i < N; i++) begin
      m_miss[i] = a[i] || (m_miss[i] && !b[i]);
      m_lop[i]  = c[i] || (m_lop[i] && !d[i]);
    end
    if (win >= 0) m_ptr = (win + 1) % N;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; rdy = '0; spc = '0; ms = '0; md = '0; ls = '0; ld = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    check("R10", 4'hF, 0, 0, 0, 0, 0);          // pointer at 0 -> thread 0
    check("R2",  4'hF, 0, 4'b0010, 0, 0, 0);    // thread1 masked now -> 2
    check("R2",  4'b0010, 0, 0, 0, 0, 0);       // stalled -> none
    check("R2",  4'b0010, 0, 0, 4'b0010, 0, 0); // done cycle still masked
    check("R2",  4'b0010, 0, 0, 0, 0, 0);       // available -> 1
    check("R3",  4'b1000, 0, 0, 0, 4'b1000, 0);
    check("R11", 4'b1000, 0, 0, 0, 4'b1000, 4'b1000);
    check("R3",  4'b1000, 0, 0, 0, 0, 4'b1000);
    check("R3",  4'b1000, 0, 0, 0, 0, 0);       // -> 3
    check("R4",  4'hF, 4'b0001, 0, 0, 0, 0);    // ptr 0, thread0 speculating -> 1
    check("R5",  4'hF, 4'hF, 0, 0, 0, 0);       // all speculating -> 2
    check("R4",  4'b0011, 4'b0001, 0, 0, 0, 0); // ptr 3, upper tier only 1
    check("R8",  4'h0, 0, 0, 0, 0, 0);          // nothing, ptr stays 2
    check("R8",  4'hF, 0, 0, 0, 0, 0);          // -> 2
    check("R7",  4'hF, 0, 0, 0, 0, 0);          // -> 3
    check("R7",  4'hF, 0, 0, 0, 0, 0);          // wrap -> 0
    check("R1",  4'hF, 0, 4'b0001, 0, 0, 0);    // thread0 flagged
    rst = 1'b1; rdy = '0; ms = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R10", 4'b0001, 0, 0, 0, 0, 0);       // miss flag cleared by reset
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] a, b, c, d;
      a = 4'($urandom) & 4'($urandom) & 4'($urandom);
      b = 4'($urandom) & 4'($urandom);
      c = 4'($urandom) & 4'($urandom) & 4'($urandom);
      d = 4'($urandom) & 4'($urandom);
      check("R6", 4'($urandom), 4'($urandom), a, b, c, d);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule